// File: doc/BRIEF.md
# Configuration Access Request Engine

This block sits between a host that wants to read or write the configuration space of devices below a root port and the outbound request path of that port. A host request names a bus, device and function, a register offset, an access width of one, two or four bytes, write data and a direction. The engine first decides whether the target can exist at all. A target on the root port's own bus can only be device 0. For a reachable target it builds one outbound descriptor: a 4-bit request type, a two-word address, byte strobes and lane-aligned write data. It then raises a start flag and holds it until the completer answers or a poll-based timeout expires.

The completer answers with a 3-bit status code, an error flag and a 32-bit data word. The engine turns this into a single response on the host side: an error flag plus data that has been aligned to the requested byte lanes. On reads, unsupported-request and retry completions are replaced by fixed substitute words. A read of the vendor-ID offset that finds the engine busy, or that runs out of time, reports the retry word so that enumeration software can keep going. Every other refused or timed-out access reports an error.

Top module: `cfg_access_engine`

## Requirements
- R1: A request whose bus equals `root_bus` and whose device is not 0 is never issued. A read of such a target answers with ones in the requested width (size 0 gives 0x000000FF, size 1 gives 0x0000FFFF, size 2 or 3 gives 0xFFFFFFFF) and no error. A write to it is dropped and answers with no error and zero data.
- R2: The outbound type is 0x8 for a read on the root bus and 0x9 for a read elsewhere. It is 0xA for a write on the root bus and 0xB for a write elsewhere.
- R3: `out_addr_lo` carries the bus in bits 27:20, the device in 19:15, the function in 14:12 and the offset with its low two bits cleared in 11:0, with bits 31:28 zero. `out_addr_hi` is zero. The descriptor stays unchanged while `out_start` is high.
- R4: For writes, `out_strb` is 0001, 0011 or 1111 (size 0, 1, or 2/3) shifted left by offset mod 4 and cut to 4 bits. `out_wdata` is the write data masked to the width and shifted left by 8 × (offset mod 4).
- R5: On completion status 0 with `cpl_err` low, a read returns `cpl_rdata` shifted right by 8 × (offset mod 4) and masked to the width, and a write returns no error. Status 0 with `cpl_err` high is an error.
- R6: On a read, status 1 substitutes 0xFFFFFFFF and status 2 substitutes 0xFFFF0001, each then aligned as in R5 and without error. On a write, statuses 1 and 2 are errors.
- R7: Status 4 (completer abort) and the unused codes 3, 5, 6 and 7 are errors. Every error response carries zero data.
- R8: A reachable request that arrives while a transaction is outstanding (`out_start` high) is refused and does not disturb it. A refused read of offset 0 answers 0xFFFF0001 with no error. Any other refused request answers with an error.
- R9: Without a completion, the transaction ends POLL_CYCLES × MAX_POLLS cycles after it is issued. A timed-out read of offset 0 answers 0xFFFF0001 with no error. Any other timed-out access answers with an error.
- R10: A response appears on `rsp_valid` for one cycle, in the cycle after the edge that sampled its cause. If a completion and a refused or unreachable request are sampled at the same edge, the completion's response comes first and the other follows one cycle later.
- R11: After reset `out_start` and `rsp_valid` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| root_bus | input | 8 | Bus number of the root port |
| req_valid | input | 1 | Host request present this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_bus | input | 8 | Target bus |
| req_dev | input | 5 | Target device |
| req_func | input | 3 | Target function |
| req_off | input | 12 | Register byte offset |
| req_size | input | 2 | 0 = 1 byte, 1 = 2 bytes, 2 or 3 = 4 bytes |
| req_wdata | input | 32 | Write data, right-justified |
| rsp_valid | output | 1 | Response strobe |
| rsp_err | output | 1 | Response is an error |
| rsp_data | output | 32 | Read result, right-justified |
| out_start | output | 1 | Outbound transaction outstanding |
| out_type | output | 4 | Outbound request type |
| out_addr_lo | output | 32 | Outbound address, low word |
| out_addr_hi | output | 32 | Outbound address, high word |
| out_wdata | output | 32 | Lane-aligned write data |
| out_strb | output | 4 | Write byte strobes |
| cpl_valid | input | 1 | Completion strobe |
| cpl_status | input | 3 | Completion status code |
| cpl_err | input | 1 | Completion error flag |
| cpl_rdata | input | 32 | Completion data word |

## Verification
Random accesses mix root-bus and downstream buses, device numbers 0 to 2, all three widths, every offset alignment and all eight completion codes, with the error flag set now and then. These cases separate the type selection, the address packing, the strobe shift and the read lane alignment from one another. Directed cases then cover the reachability filter, because a device above 0 on the root bus versus one on a downstream bus tells an exact bus compare apart from a looser one. They also cover the vendor-offset exception against a nearby nonzero offset for both the busy path and the timeout path, the exact cycle at which the timeout fires, and a completion that arrives at the same edge as a refused request, which checks the ordering of the two responses.

// File: rtl/cfgx_pkg.sv
// Shared constants and helpers for the configuration access engine.
// Assumes the fixed 32-bit data path and 8/5/3/12-bit target fields.
package cfgx_pkg;
    localparam int BUS_W  = 8;
    localparam int DEV_W  = 5;
    localparam int FN_W   = 3;
    localparam int OFF_W  = 12;
    localparam int DATA_W = 32;
    localparam int STRB_W = DATA_W / 8;

    localparam logic [3:0] TYPE_RD_LOCAL  = 4'h8;
    localparam logic [3:0] TYPE_RD_REMOTE = 4'h9;
    localparam logic [3:0] TYPE_WR_LOCAL  = 4'hA;
    localparam logic [3:0] TYPE_WR_REMOTE = 4'hB;

    localparam logic [2:0] ST_OK    = 3'd0;
    localparam logic [2:0] ST_UNSUP = 3'd1;
    localparam logic [2:0] ST_RETRY = 3'd2;

    localparam logic [DATA_W-1:0] WORD_UNSUP = 32'hFFFF_FFFF;
    localparam logic [DATA_W-1:0] WORD_RETRY = 32'hFFFF_0001;

    // Saved context of the outstanding transaction.
    typedef struct packed {
        logic             wr;
        logic [1:0]       size;
        logic [1:0]       lane;
        logic             vendor;
    } xact_ctx_t;

    // Ones covering the access width.
    function automatic logic [DATA_W-1:0] width_mask(input logic [1:0] sz);
        case (sz)
            2'd0:    width_mask = 32'h0000_00FF;
            2'd1:    width_mask = 32'h0000_FFFF;
            default: width_mask = 32'hFFFF_FFFF;
        endcase
    endfunction
endpackage

// File: rtl/cfgx_req_build.sv
// Request builder: decides reachability and forms the outbound descriptor.
// Purely combinational; assumes the caller registers the results.
module cfgx_req_build
    import cfgx_pkg::*;
(
    input  logic [BUS_W-1:0]  root_bus,
    input  logic              wr,
    input  logic [BUS_W-1:0]  bus,
    input  logic [DEV_W-1:0]  dev,
    input  logic [FN_W-1:0]   fn,
    input  logic [OFF_W-1:0]  off,
    input  logic [1:0]        size,
    input  logic [DATA_W-1:0] wdata,
    output logic              reachable,
    output logic [3:0]        typ,
    output logic [DATA_W-1:0] addr_lo,
    output logic [STRB_W-1:0] strb,
    output logic [DATA_W-1:0] wdata_al
);
    localparam int PAD_W = DATA_W - BUS_W - DEV_W - FN_W - OFF_W;

    logic              local_bus;
    logic [STRB_W-1:0] base_strb;
    logic [2*STRB_W-1:0] wide_strb;

    // Target filter and request type selection.
    always_comb begin
        local_bus = (bus == root_bus);
        reachable = !(local_bus && (dev != '0));
        if (wr) typ = local_bus ? TYPE_WR_LOCAL : TYPE_WR_REMOTE;
        else    typ = local_bus ? TYPE_RD_LOCAL : TYPE_RD_REMOTE;
    end

    // Address packing with the offset forced to a dword boundary.
    always_comb addr_lo = {{PAD_W{1'b0}}, bus, dev, fn, off[OFF_W-1:2], 2'b00};

    // Byte strobes and lane placement of write data.
    always_comb begin
        case (size)
            2'd0:    base_strb = 4'b0001;
            2'd1:    base_strb = 4'b0011;
            default: base_strb = 4'b1111;
        endcase
        wide_strb = {{STRB_W{1'b0}}, base_strb} << off[1:0];
        strb      = wide_strb[STRB_W-1:0];
        wdata_al  = (wdata & width_mask(size)) << {off[1:0], 3'b000};
    end
endmodule

// File: rtl/cfgx_cpl_map.sv
// Completion mapper: turns a status code, error flag and data word into
// an error flag and right-justified read data. Combinational.
module cfgx_cpl_map
    import cfgx_pkg::*;
(
    input  xact_ctx_t         ctx,
    input  logic [2:0]        status,
    input  logic              cerr,
    input  logic [DATA_W-1:0] rdata,
    output logic              err,
    output logic [DATA_W-1:0] data
);
    logic [DATA_W-1:0] raw;

    // Status decode with read substitutes.
    always_comb begin
        raw = '0;
        err = 1'b1;
        case (status)
            ST_OK:    begin err = cerr;   raw = rdata;      end
            ST_UNSUP: begin err = ctx.wr; raw = WORD_UNSUP; end
            ST_RETRY: begin err = ctx.wr; raw = WORD_RETRY; end
            default:  err = 1'b1;
        endcase
    end

    // Lane alignment of the selected word; errors and writes give zero.
    always_comb begin
        if (err || ctx.wr) data = '0;
        else               data = (raw >> {ctx.lane, 3'b000}) & width_mask(ctx.size);
    end
endmodule

// File: rtl/cfgx_poll_timer.sv
// Poll timer: counts POLL_CYCLES-cycle intervals while running and flags
// expiry in the last cycle of interval MAX_POLLS. Clear restarts it.
module cfgx_poll_timer #(
    parameter int POLL_CYCLES = 1000,
    parameter int MAX_POLLS   = 1500
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic run,
    output logic expire
);
    localparam int TW = $clog2(POLL_CYCLES) + 1;
    localparam int PW = $clog2(MAX_POLLS) + 1;
    localparam logic [TW-1:0] TICK_LAST = TW'(POLL_CYCLES - 1);
    localparam logic [PW-1:0] POLL_LAST = PW'(MAX_POLLS - 1);

    logic [TW-1:0] tick_q;
    logic [PW-1:0] poll_q;

    // Interval and poll counters.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            tick_q <= '0;
            poll_q <= '0;
        end else if (run) begin
            if (tick_q == TICK_LAST) begin
                tick_q <= '0;
                if (poll_q != POLL_LAST) poll_q <= poll_q + 1'b1;
            end else begin
                tick_q <= tick_q + 1'b1;
            end
        end
    end

    // Expiry in the final cycle of the final interval.
    always_comb expire = run && (tick_q == TICK_LAST) && (poll_q == POLL_LAST);
endmodule

// File: rtl/cfg_access_engine.sv
// Configuration access engine top: accepts one host request at a time,
// issues a descriptor, waits for a completion or timeout, and answers.
// Assumes one completion per issued descriptor; responses are one-cycle pulses.
module cfg_access_engine
    import cfgx_pkg::*;
#(
    parameter int POLL_CYCLES = 1000,
    parameter int MAX_POLLS   = 1500
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [7:0]        root_bus,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [7:0]        req_bus,
    input  logic [4:0]        req_dev,
    input  logic [2:0]        req_func,
    input  logic [11:0]       req_off,
    input  logic [1:0]        req_size,
    input  logic [31:0]       req_wdata,
    output logic              rsp_valid,
    output logic              rsp_err,
    output logic [31:0]       rsp_data,
    output logic              out_start,
    output logic [3:0]        out_type,
    output logic [31:0]       out_addr_lo,
    output logic [31:0]       out_addr_hi,
    output logic [31:0]       out_wdata,
    output logic [3:0]        out_strb,
    input  logic              cpl_valid,
    input  logic [2:0]        cpl_status,
    input  logic              cpl_err,
    input  logic [31:0]       cpl_rdata
);
    logic              reach, accept, tmo;
    logic [3:0]        b_type;
    logic [DATA_W-1:0] b_addr, b_wdata;
    logic [STRB_W-1:0] b_strb;
    logic              busy_q;
    xact_ctx_t         ctx_q;
    logic              m_err;
    logic [DATA_W-1:0] m_data;
    logic              c_fire, c_err, n_fire, n_err, hold_v, hold_err;
    logic [DATA_W-1:0] c_data, n_data, hold_data;

    cfgx_req_build u_build (
        .root_bus (root_bus), .wr (req_write), .bus (req_bus), .dev (req_dev),
        .fn (req_func), .off (req_off), .size (req_size), .wdata (req_wdata),
        .reachable (reach), .typ (b_type), .addr_lo (b_addr),
        .strb (b_strb), .wdata_al (b_wdata)
    );

    cfgx_cpl_map u_map (
        .ctx (ctx_q), .status (cpl_status), .cerr (cpl_err),
        .rdata (cpl_rdata), .err (m_err), .data (m_data)
    );

    cfgx_poll_timer #(.POLL_CYCLES(POLL_CYCLES), .MAX_POLLS(MAX_POLLS)) u_timer (
        .clk (clk), .rst_n (rst_n), .clr (accept),
        .run (busy_q && !cpl_valid), .expire (tmo)
    );

    // Response sources: transaction end (C) and immediate answers (N).
    always_comb begin
        accept = req_valid && reach && !busy_q;
        c_fire = busy_q && (cpl_valid || tmo);
        if (cpl_valid) begin
            c_err = m_err; c_data = m_data;
        end else begin
            c_err = !ctx_q.vendor; c_data = ctx_q.vendor ? WORD_RETRY : '0;
        end
        n_fire = req_valid && (!reach || busy_q);
        if (!reach) begin
            n_err = 1'b0; n_data = req_write ? '0 : width_mask(req_size);
        end else begin
            n_err  = !(!req_write && req_off == '0);
            n_data = n_err ? '0 : WORD_RETRY;
        end
    end

    // Response register with a one-entry hold for same-edge collisions.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_valid <= 1'b0; rsp_err <= 1'b0; rsp_data <= '0;
            hold_v <= 1'b0; hold_err <= 1'b0; hold_data <= '0;
        end else if (c_fire || hold_v) begin
            rsp_valid <= 1'b1;
            rsp_err   <= c_fire ? c_err  : hold_err;
            rsp_data  <= c_fire ? c_data : hold_data;
            hold_v    <= n_fire;
            hold_err  <= n_err;
            hold_data <= n_data;
        end else begin
            rsp_valid <= n_fire;
            rsp_err   <= n_fire & n_err;
            rsp_data  <= n_fire ? n_data : '0;
        end
    end

    // Transaction state and descriptor capture.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_q <= 1'b0; ctx_q <= '0;
            out_type <= '0; out_addr_lo <= '0; out_wdata <= '0; out_strb <= '0;
        end else if (accept) begin
            busy_q      <= 1'b1;
            ctx_q       <= '{wr: req_write, size: req_size, lane: req_off[1:0],
                             vendor: (!req_write && req_off == '0)};
            out_type    <= b_type;
            out_addr_lo <= b_addr;
            out_wdata   <= req_write ? b_wdata : '0;
            out_strb    <= req_write ? b_strb : '0;
        end else if (c_fire) begin
            busy_q <= 1'b0;
        end
    end

    // Start flag mirrors the outstanding state; upper address word unused.
    always_comb begin
        out_start   = busy_q;
        out_addr_hi = '0;
    end
endmodule

// File: rtl/cfg_access_engine_chk.sv
// Property checker for cfg_access_engine, attached by bind below.
module cfg_access_engine_chk (
    input logic        clk,
    input logic        rst_n,
    input logic [7:0]  root_bus,
    input logic        req_valid,
    input logic        req_write,
    input logic [7:0]  req_bus,
    input logic [4:0]  req_dev,
    input logic [11:0] req_off,
    input logic        rsp_valid,
    input logic        rsp_err,
    input logic [31:0] rsp_data,
    input logic        out_start,
    input logic [3:0]  out_type,
    input logic [31:0] out_addr_lo,
    input logic [3:0]  out_strb,
    input logic        cpl_valid
);
    logic unreach;
    always_comb unreach = (req_bus == root_bus) && (req_dev != 5'd0);

    AST_UNREACH_NOT_ISSUED: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && unreach && !out_start) |=> !out_start); // R1
    AST_TYPE_MATCHES_BUS: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(out_start) |-> (out_type[3:2] == 2'b10 &&
                              out_type[0] == (out_addr_lo[27:20] != root_bus))); // R2
    AST_DESC_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (out_start && $past(out_start)) |-> ($stable(out_addr_lo) && $stable(out_type))); // R3
    AST_WRITE_HAS_STRB: assert property (@(posedge clk) disable iff (!rst_n)
        (out_start && out_type[1]) |-> (out_strb != 4'd0)); // R4
    AST_ERR_DATA_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_err) |-> (rsp_data == 32'd0)); // R7
    AST_BUSY_VENDOR_RETRY: assert property (@(posedge clk) disable iff (!rst_n)
        (out_start && !cpl_valid && req_valid && !unreach && !req_write && req_off == 12'd0)
        |=> (rsp_valid && !rsp_err && rsp_data == 32'hFFFF_0001)); // R8
    AST_CPL_ENDS_XACT: assert property (@(posedge clk) disable iff (!rst_n)
        (out_start && cpl_valid) |=> (!out_start && rsp_valid)); // R10
    AST_COLLIDE_TWO_RSP: assert property (@(posedge clk) disable iff (!rst_n)
        (out_start && cpl_valid && req_valid) |=> rsp_valid ##1 rsp_valid); // R10
endmodule

bind cfg_access_engine cfg_access_engine_chk chk_i (
    .clk (clk), .rst_n (rst_n), .root_bus (root_bus), .req_valid (req_valid),
    .req_write (req_write), .req_bus (req_bus), .req_dev (req_dev),
    .req_off (req_off), .rsp_valid (rsp_valid), .rsp_err (rsp_err),
    .rsp_data (rsp_data), .out_start (out_start), .out_type (out_type),
    .out_addr_lo (out_addr_lo), .out_strb (out_strb), .cpl_valid (cpl_valid)
);

// File: tb/cfg_access_engine_tb_top.sv
`timescale 1ns/1ps
module cfg_access_engine_tb_top;
    localparam int PC = 3;
    localparam int MP = 4;
    localparam int TMO = PC * MP;
    localparam logic [7:0] ROOT = 8'h02;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [7:0] root_bus = ROOT;
    logic req_valid = 0, req_write = 0;
    logic [7:0] req_bus = 0;
    logic [4:0] req_dev = 0;
    logic [2:0] req_func = 0;
    logic [11:0] req_off = 0;
    logic [1:0] req_size = 0;
    logic [31:0] req_wdata = 0;
    logic rsp_valid, rsp_err, out_start;
    logic [31:0] rsp_data, out_addr_lo, out_addr_hi, out_wdata;
    logic [3:0] out_type, out_strb;
    logic cpl_valid = 0, cpl_err = 0;
    logic [2:0] cpl_status = 0;
    logic [31:0] cpl_rdata = 0;
    int n_chk = 0, n_bad = 0;

    always #2 clk = ~clk;

    cfg_access_engine #(.POLL_CYCLES(PC), .MAX_POLLS(MP)) dut_i (
        .clk, .rst_n, .root_bus, .req_valid, .req_write, .req_bus, .req_dev,
        .req_func, .req_off, .req_size, .req_wdata, .rsp_valid, .rsp_err,
        .rsp_data, .out_start, .out_type, .out_addr_lo, .out_addr_hi,
        .out_wdata, .out_strb, .cpl_valid, .cpl_status, .cpl_err, .cpl_rdata
    );

    task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk); #1;
    endtask

    function automatic logic [31:0] wmask(input logic [1:0] sz);
        return sz == 0 ? 32'hFF : sz == 1 ? 32'hFFFF : 32'hFFFFFFFF;
    endfunction
    function automatic logic [3:0] e_type(input bit wr, input logic [7:0] bus);
        return {2'b10, wr, bus != ROOT};
    endfunction
    function automatic logic [31:0] e_addr(input logic [7:0] b, input logic [4:0] d,
                                           input logic [2:0] f, input logic [11:0] o);
        return {4'h0, b, d, f, o & 12'hFFC};
    endfunction
    function automatic logic [3:0] e_strb(input logic [1:0] sz, input logic [11:0] o);
        logic [7:0] s;
        s = (sz == 0 ? 8'h1 : sz == 1 ? 8'h3 : 8'hF) << o[1:0];
        return s[3:0];
    endfunction
    // Returns {err, data} for a completion.
    function automatic logic [32:0] e_cpl(input bit wr, input logic [2:0] st, input bit ce,
                                          input logic [31:0] rd, input logic [11:0] o,
                                          input logic [1:0] sz);
        logic [31:0] w;
        bit er;
        case (st)
            3'd0: begin er = ce; w = rd; end
            3'd1: begin er = wr; w = 32'hFFFFFFFF; end
            3'd2: begin er = wr; w = 32'hFFFF0001; end
            default: begin er = 1; w = 0; end
        endcase
        if (er || wr) return {er, 32'd0};
        return {1'b0, (w >> (8 * o[1:0])) & wmask(sz)};
    endfunction

    task automatic drive_req(input bit wr, input logic [7:0] b, input logic [4:0] d,
                             input logic [2:0] f, input logic [11:0] o,
                             input logic [1:0] sz, input logic [31:0] wd);
        req_valid = 1; req_write = wr; req_bus = b; req_dev = d; req_func = f;
        req_off = o; req_size = sz; req_wdata = wd;
    endtask

    // One complete access; tmode=1 lets it time out.
    task automatic access(input bit wr, input logic [7:0] b, input logic [4:0] d,
                          input logic [2:0] f, input logic [11:0] o, input logic [1:0] sz,
                          input logic [31:0] wd, input logic [2:0] st, input bit ce,
                          input logic [31:0] rd, input int dly, input bit tmode);
        logic [32:0] ex;
        int waited;
        drive_req(wr, b, d, f, o, sz, wd);
        tick();
        req_valid = 0;
        if (b == ROOT && d != 0) begin
            chk(!out_start, "R1 not issued", out_start, 0);
            chk(rsp_valid && !rsp_err && rsp_data == (wr ? 32'd0 : wmask(sz)),
                "R1 unreachable response", {rsp_valid, rsp_err, rsp_data},
                {2'b10, (wr ? 32'd0 : wmask(sz))});
            return;
        end
        chk(out_start && !rsp_valid, "R10 issued no response", {out_start, rsp_valid}, 2'b10);
        chk(out_type == e_type(wr, b), "R2 type", out_type, e_type(wr, b));
        chk(out_addr_lo == e_addr(b, d, f, o) && out_addr_hi == 0, "R3 address",
            out_addr_lo, e_addr(b, d, f, o));
        if (wr) begin
            chk(out_strb == e_strb(sz, o), "R4 strobe", out_strb, e_strb(sz, o));
            chk(out_wdata == ((wd & wmask(sz)) << (8 * o[1:0])), "R4 write data",
                out_wdata, (wd & wmask(sz)) << (8 * o[1:0]));
        end
        if (tmode) begin
            waited = 0;
            while (!rsp_valid && waited < TMO + 4) begin tick(); waited++; end
            ex = (!wr && o == 0) ? {1'b0, 32'hFFFF0001} : {1'b1, 32'd0};
            chk(waited == TMO, "R9 timeout cycle", waited, TMO);
            chk({rsp_err, rsp_data} == ex && !out_start, "R9 timeout response",
                {rsp_err, rsp_data}, ex);
            return;
        end
        for (int i = 0; i < dly; i++) tick();
        cpl_valid = 1; cpl_status = st; cpl_err = ce; cpl_rdata = rd;
        tick();
        cpl_valid = 0;
        ex = e_cpl(wr, st, ce, rd, o, sz);
        chk(rsp_valid && {rsp_err, rsp_data} == ex, "R5 R6 R7 completion mapping",
            {rsp_valid, rsp_err, rsp_data}, {1'b1, ex});
        tick();
        chk(!rsp_valid && !out_start, "R10 single pulse", {rsp_valid, out_start}, 0);
    endtask

    initial begin
        #(4 * 150000);
        n_bad++; n_chk++;
        $display("FAIL watchdog expired");
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        void'($urandom(32'd2024));
        tick(); tick();
        rst_n = 1;
        chk(!out_start && !rsp_valid, "R11 reset state", {out_start, rsp_valid}, 0);

        // Directed cases.
        access(0, ROOT, 5'd1, 3'd0, 12'h000, 2'd1, 0, 0, 0, 0, 0, 0);     // R1 read, 16 bit
        access(1, ROOT, 5'd3, 3'd0, 12'h010, 2'd2, 32'h1234, 0, 0, 0, 0, 0); // R1 write
        access(0, 8'h05, 5'd3, 3'd2, 12'h0A7, 2'd0, 0, 3'd0, 0, 32'hA1B2C3D4, 1, 0); // R5
        access(0, ROOT, 5'd0, 3'd1, 12'h002, 2'd1, 0, 3'd0, 1, 32'h11223344, 0, 0);  // R5 err flag
        access(0, ROOT, 5'd0, 3'd0, 12'h002, 2'd1, 0, 3'd2, 0, 0, 2, 0);   // R6 retry -> FFFF
        access(1, 8'h07, 5'd1, 3'd0, 12'h043, 2'd1, 32'hBEEF, 3'd1, 0, 0, 0, 0); // R4 R6
        access(0, 8'h07, 5'd1, 3'd0, 12'h040, 2'd2, 0, 3'd4, 0, 32'h5, 0, 0);    // R7 abort
        access(0, 8'h07, 5'd1, 3'd0, 12'h040, 2'd2, 0, 3'd6, 0, 32'h5, 0, 0);    // R7 unknown
        access(0, ROOT, 5'd0, 3'd0, 12'h000, 2'd2, 0, 0, 0, 0, 0, 1);      // R9 vendor
        access(0, ROOT, 5'd0, 3'd0, 12'h004, 2'd2, 0, 0, 0, 0, 0, 1);      // R9 other read
        access(1, 8'h09, 5'd0, 3'd0, 12'h000, 2'd2, 32'h1, 0, 0, 0, 0, 1); // R9 write

        // R8: refusals while busy, then R10 collision ordering.
        drive_req(0, 8'h04, 5'd2, 3'd0, 12'h08C, 2'd2, 0);
        tick();
        drive_req(0, ROOT, 5'd0, 3'd0, 12'h000, 2'd2, 0);
        tick();
        chk(rsp_valid && !rsp_err && rsp_data == 32'hFFFF0001, "R8 busy vendor read",
            {rsp_err, rsp_data}, {1'b0, 32'hFFFF0001});
        drive_req(0, ROOT, 5'd0, 3'd0, 12'h008, 2'd2, 0);
        tick();
        chk(rsp_valid && rsp_err && rsp_data == 0, "R8 busy other read", {rsp_err, rsp_data}, {1'b1, 32'd0});
        chk(out_addr_lo == e_addr(8'h04, 5'd2, 3'd0, 12'h08C), "R8 outstanding intact",
            out_addr_lo, e_addr(8'h04, 5'd2, 3'd0, 12'h08C));
        drive_req(1, 8'h01, 5'd0, 3'd0, 12'h000, 2'd2, 32'h7);
        cpl_valid = 1; cpl_status = 0; cpl_err = 0; cpl_rdata = 32'hCAFEF00D;
        tick();
        req_valid = 0; cpl_valid = 0;
        chk(rsp_valid && !rsp_err && rsp_data == 32'hCAFEF00D, "R10 completion first",
            {rsp_err, rsp_data}, {1'b0, 32'hCAFEF00D});
        tick();
        chk(rsp_valid && rsp_err, "R10 refusal second", {rsp_valid, rsp_err}, 2'b11);
        tick();
        chk(!rsp_valid && !out_start, "R10 quiet after", {rsp_valid, out_start}, 0);

        // Random accesses.
        for (int k = 0; k < 80; k++) begin
            logic [7:0] b;
            logic [2:0] st;
            int sel;
            sel = $urandom_range(0, 2);
            b = sel == 0 ? ROOT : sel == 1 ? ROOT + 8'd1 : 8'($urandom);
            st = 3'($urandom_range(0, 7));
            if ($urandom_range(0, 2) == 0) st = 3'd0;
            access(1'($urandom), b, 5'($urandom_range(0, 2)), 3'($urandom),
                   12'($urandom), 2'($urandom), $urandom, st,
                   $urandom_range(0, 7) == 0, $urandom, $urandom_range(0, 3),
                   $urandom_range(0, 9) == 0);
        end

        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule